// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts ticks of a slow time base, a 32.768 kHz clock enable. Software cannot stop the count. It chooses one of seven timeout lengths with a 3-bit code. When the count first reaches the chosen length, the block emits a one-cycle non-maskable interrupt request. If software does not clear the watchdog before the count reaches the same length again, the block raises a reset request. That request stays high until the block itself is reset.

Software services the watchdog with a one-cycle clear strobe. The strobe zeroes the count and returns the escalation to its first stage. A new period code takes effect only at a clear or a reset, so changing the code in the middle of a count cannot shorten the current timeout. The parameter `TICK_SHIFT` divides every period by a power of two, so short configurations can be built.

Top module: `wdt_two_stage`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `nmi_pulse` and `rst_req` are 0, and the tick count is zero.
- R2: The period code selects this many ticks before an overflow, each shifted right by `TICK_SHIFT`: code 0 gives 768, code 1 gives 1024, code 2 gives 2048, code 3 gives 4096, code 4 gives 16384, code 5 gives 65536, and codes 6 and 7 both give 262144.
- R3: When the tick count reaches the period and the first stage is not yet marked, `nmi_pulse` goes high for exactly one cycle. It goes high in the cycle after the clock edge that carries the last tick. `rst_req` stays 0.
- R4: A second overflow with no clear since the first one sets `rst_req` in the cycle after the edge carrying the last tick. This second overflow gives no `nmi_pulse`.
- R5: Once set, `rst_req` stays 1 through clears and further overflows until `rst` is asserted.
- R6: A clear strobe zeroes the count and the first-stage mark, so the next overflow comes a full period later and is treated as a first overflow.
- R7: A change of `period_sel` has no effect on the running count. It is loaded only by a clear or a reset.
- R8: The count advances only on edges where `tick_en` is 1. It wraps to zero at each overflow and keeps running.
- R9: A clear on the same edge as a would-be overflow wins: no `nmi_pulse` follows, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also loads the period code |
| tick_en | input | 1 | One-cycle enable for each low-speed tick |
| period_sel | input | 3 | Timeout code, loaded at clear or reset |
| clear | input | 1 | Service strobe: zeroes count and stage |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request on the first overflow |
| rst_req | output | 1 | Sticky reset request on the second overflow |

## Verification
A count that is off by one moves the interrupt pulse one tick early or late. The bench samples the pulse on the exact edge where the count should end, so such an error shows there. If the stage mark is not cleared, the first overflow after a clear raises a reset request instead of an interrupt, one full period after the clear. If the period register reloads at the wrong time, the overflow lands at the new length instead of the old one. That shows at the first overflow after the code changes. If the reset request is not held, it drops on the cycle right after a clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SEL_W = 3;

  // Base tick counts of the low-speed time base per period code.
  function automatic int unsigned base_ticks(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    base_ticks = 32'd768;
      3'd1:    base_ticks = 32'd1024;
      3'd2:    base_ticks = 32'd2048;
      3'd3:    base_ticks = 32'd4096;
      3'd4:    base_ticks = 32'd16384;
      3'd5:    base_ticks = 32'd65536;
      default: base_ticks = 32'd262144; // codes 6 and 7
    endcase
  endfunction
endpackage

// File: rtl/wdt_period_reg.sv
module wdt_period_reg
  import wdt_pkg::*;
#(
  parameter int LIM_W      = 19,
  parameter int TICK_SHIFT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [SEL_W-1:0] period_sel,
  output logic [LIM_W-1:0] limit
);
  always_ff @(posedge clk) begin
    if (rst || clear)
      limit <= LIM_W'(base_ticks(period_sel) >> TICK_SHIFT);
  end

  // R7: the limit only moves at a clear
  assert_limit_held_R7: assert property (@(posedge clk) disable iff (rst)
    !clear |=> $stable(limit));
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CNT_W = 18,
  parameter int LIM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             clear,
  input  logic [LIM_W-1:0] limit,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = ({1'b0, cnt} == (limit - LIM_W'(1)));
  assign ovf    = tick_en && !clear && at_end;

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (ovf)      cnt <= '0;
    else if (tick_en)  cnt <= cnt + CNT_W'(1);
  end

  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !clear) |=> $stable(cnt));
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));
  assert_below_limit_R2: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} < limit));
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic ovf,
  output logic nmi_pulse,
  output logic rst_req
);
  logic stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1    <= 1'b0;
      nmi_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      nmi_pulse <= ovf && !stage1;
      if (clear)
        stage1 <= 1'b0;
      else if (ovf)
        stage1 <= 1'b1;
      if (ovf && stage1)
        rst_req <= 1'b1;
    end
  end

  assert_nmi_single_R3: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |=> !nmi_pulse);
  assert_first_ovf_nmi_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf && !stage1) |=> nmi_pulse);
  assert_second_ovf_reset_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf && stage1) |=> (rst_req && !nmi_pulse));
  assert_req_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 18,
  parameter int TICK_SHIFT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] period_sel,
  input  logic             clear,
  output logic             nmi_pulse,
  output logic             rst_req
);
  localparam int LIM_W = CNT_W + 1;

  logic [LIM_W-1:0] limit;
  logic             ovf;

  wdt_period_reg #(.LIM_W(LIM_W), .TICK_SHIFT(TICK_SHIFT)) u_period (
    .clk(clk), .rst(rst), .clear(clear), .period_sel(period_sel), .limit(limit)
  );

  wdt_tick_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_count (
    .clk(clk), .rst(rst), .tick_en(tick_en), .clear(clear),
    .limit(limit), .ovf(ovf)
  );

  wdt_escalate u_esc (
    .clk(clk), .rst(rst), .clear(clear), .ovf(ovf),
    .nmi_pulse(nmi_pulse), .rst_req(rst_req)
  );

  // R9: a clear suppresses the overflow on its own edge
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> !nmi_pulse);
endmodule

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;
  localparam int SHIFT = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic [2:0] period_sel = 3'd0;
  logic       clear = 1'b0;
  logic       nmi_pulse, rst_req;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  wdt_two_stage #(.CNT_W(18), .TICK_SHIFT(SHIFT)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .period_sel(period_sel),
    .clear(clear), .nmi_pulse(nmi_pulse), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  function automatic int exp_len(input int code);
    int b;
    case (code)
      0: b = 768;
      1: b = 1024;
      2: b = 2048;
      3: b = 4096;
      4: b = 16384;
      5: b = 65536;
      default: b = 262144;
    endcase
    return b >> SHIFT;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset(input int code);
    period_sel = 3'(code);
    tick_en = 1'b1;
    clear = 1'b0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic pulse_clear();
    clear = 1'b1;
    step(1);
    clear = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int len;
    int ticks;
    int bad;
    int hit;
    // Sweep every code: both escalation stages, stickiness, clear.
    for (int c = 0; c < 8; c++) begin
      len = exp_len(c);
      do_reset(c);
      check(nmi_pulse == 0 && rst_req == 0, "R1", {nmi_pulse, rst_req}, 0);
      step(len - 1);
      check(nmi_pulse == 0, "R2", nmi_pulse, 0);
      step(1);
      check(nmi_pulse == 1, "R3", nmi_pulse, 1);
      check(rst_req == 0, "R3", rst_req, 0);
      step(1);
      check(nmi_pulse == 0, "R3", nmi_pulse, 0);
      step(len - 2);
      check(rst_req == 0, "R4", rst_req, 0);
      step(1);
      check(rst_req == 1 && nmi_pulse == 0, "R4", {rst_req, nmi_pulse}, 2);
      pulse_clear();
      check(rst_req == 1, "R5", rst_req, 1);
      step(len);
      check(nmi_pulse == 1 && rst_req == 1, "R5", {nmi_pulse, rst_req}, 3);
      do_reset(c);
      check(rst_req == 0, "R5", rst_req, 0);
    end

    // R6: a clear after the first overflow restarts the first stage.
    len = exp_len(0);
    do_reset(0);
    step(len);
    pulse_clear();
    step(len - 1);
    check(nmi_pulse == 0, "R6", nmi_pulse, 0);
    step(1);
    check(nmi_pulse == 1 && rst_req == 0, "R6", {nmi_pulse, rst_req}, 2);
    step(len);
    check(rst_req == 1, "R6", rst_req, 1);

    // R9: a clear on the overflow edge suppresses it.
    do_reset(0);
    step(len - 1);
    pulse_clear();
    check(nmi_pulse == 0, "R9", nmi_pulse, 0);
    step(len - 1);
    check(nmi_pulse == 0, "R9", nmi_pulse, 0);
    step(1);
    check(nmi_pulse == 1 && rst_req == 0, "R9", {nmi_pulse, rst_req}, 2);

    // R7: a code change mid-count waits for the next clear.
    do_reset(3);
    step(10);
    period_sel = 3'd0;
    hit = 0;
    for (int i = 0; i < exp_len(3) - 11; i++) begin
      step(1);
      if (nmi_pulse) hit++;
    end
    check(hit == 0, "R7", hit, 0);
    step(1);
    check(nmi_pulse == 1, "R7", nmi_pulse, 1);
    pulse_clear();
    step(exp_len(0) - 1);
    check(nmi_pulse == 0, "R7", nmi_pulse, 0);
    step(1);
    check(nmi_pulse == 1, "R7", nmi_pulse, 1);

    // R8: the count advances only on tick-enabled edges.
    do_reset(0);
    ticks = 0;
    bad = 0;
    hit = 0;
    for (int i = 0; ticks < len + 3; i++) begin
      tick_en = (i % 3) != 0;
      step(1);
      if (tick_en) ticks++;
      if (nmi_pulse != (tick_en && ticks == len)) bad++;
      if (nmi_pulse) hit++;
    end
    tick_en = 1'b1;
    check(bad == 0 && hit == 1, "R8", bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule